// File: doc/BRIEF.md
# Single-Wire Parity-Framed Byte Link

This block moves one byte at a time across a single shared wire that a pull-up holds high when no one drives it. One end drives while the other listens. The `tx_mode` input chooses the role. When it is high the block owns the wire and can send. When it is low the block lets go of the wire and listens for a byte. The pad itself is outside the block. The block sees it as three signals: a drive enable, a drive value and the sampled wire level.

Each sent byte opens with a timing mark. The wire is held low for one bit period and then raised. The rising edge is the reference the listener locks onto. A short high mark of half a period (rounded down) follows. Then come the eight data bits, most significant first, and an even-parity bit. After that the sender leaves the wire low, so the next mark makes a fresh rising edge. The listener passes the wire through a two-flop synchroniser, waits for that edge and samples each bit halfway through its period. It then reports the byte and a parity-error flag in a single-cycle pulse. The bit period is set in microseconds and converted to clock cycles from the clock frequency. The allowed values are 4, 6, 12, 24, 36 or 48 µs, and the default is 6 µs.

The sender works as a state machine with these states:
- `TX_IDLE` moves to `TX_SYNC_LO` on a start request.
- `TX_SYNC_LO` moves to `TX_SYNC_HI` after one period.
- `TX_SYNC_HI` moves to `TX_DATA` after half a period.
- `TX_DATA` moves to `TX_PARITY` after the eighth bit.
- `TX_PARITY` moves back to `TX_IDLE` after one period.
- Dropping `tx_mode` forces the sender back to `TX_IDLE` from any state.

The listener works as a state machine with these states:
- `RX_HUNT` moves to `RX_WAIT_HI` when the wire is low. It moves straight to `RX_BITS` if the wire stays high for five periods.
- `RX_WAIT_HI` moves to `RX_BITS` on a high wire.
- `RX_BITS` moves to `RX_TAIL` after the ninth sample.
- `RX_TAIL` moves back to `RX_HUNT` when it emits the result.
- A high `tx_mode` holds the listener in `RX_HUNT`.

Top module: `sw_byte_link`

## Requirements
In these requirements, BIT is the bit period in clock cycles. HALF1 = floor(BIT/2) and HALF2 = BIT − HALF1. S is the clock edge that accepts a start request.

- R1: After reset, `tx_busy` and `rx_valid` are 0. With `tx_mode` = 1 and no byte sent yet, the block drives the wire high (`pad_oe` = 1, `pad_out` = 1).
- R2: A `tx_start` seen with `tx_mode` = 1 while idle starts a frame, and `tx_busy` rises in the cycle after S. `pad_out` is 0 for the BIT cycles that follow S. The eight data bits then follow, bit 7 first, each held for BIT cycles, starting BIT + HALF1 cycles after S.
- R3: The bit after the data, held for BIT cycles, is the even-parity bit. It is 1 exactly when the byte has an odd number of ones.
- R4: `tx_busy` lasts exactly BIT + HALF1 + 9·BIT cycles. Afterwards `pad_out` stays 0 until the next frame. A start given in the first idle cycle is accepted, and that frame again opens with BIT low cycles.
- R5: A `tx_start` is ignored while `tx_busy` is 1, and also while `tx_mode` = 0. The frame in progress and the parked wire level do not change.
- R6: With `tx_mode` = 0, `pad_oe` and `pad_out` are both 0, and `tx_busy` is 0 from the cycle after `tx_mode` was seen low.
- R7: Call P0 the first clock edge at which `pad_in` is high after a low. Data bit k (k = 0 is the MSB) is the `pad_in` level just before edge P0 + 2·HALF1 + k·BIT. The parity bit uses k = 8. `rx_data` changes only in the cycle where `rx_valid` is 1.
- R8: `rx_valid` is 1 for one cycle only, visible after edge P0 + 2 + 2·HALF1 + 8·BIT + HALF2. In that cycle `rx_data` holds the byte. `rx_parity_err` is 1 exactly when the received parity bit differs from the XOR of the eight data bits.
- R9: In listen mode, if the wire stays high for 5·BIT cycles without going low, the listener takes that moment as its timing reference and reads a byte. On a wire held high it reports 0xFF with `rx_parity_err` = 1.
- R10: In a sent frame the high mark between the low sync pulse and the first data bit lasts HALF1 cycles. With an odd BIT the receive half-periods split as floor and remainder.
- R11: While `tx_mode` = 1 the listener is held idle, and `rx_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1: drive the wire and send; 0: release the wire and listen |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_data | input | 8 | Byte to send |
| tx_busy | output | 1 | A frame is being sent |
| pad_oe | output | 1 | Drive enable to the pad |
| pad_out | output | 1 | Level driven when `pad_oe` is 1 |
| pad_in | input | 1 | Sampled wire level |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse marking a received byte |
| rx_parity_err | output | 1 | Parity mismatch for the byte in `rx_data` |

## Verification
The bench uses an odd bit period, so the two receive half-periods differ. A design that rounds the split the wrong way shifts both the sync high mark and the moment `rx_valid` appears by a cycle, and the per-clock comparison catches that. The bench sends bytes whose parity and MSB patterns differ (0xA5, 0x80, 0x00, 0xFF), back to back and with a rejected start in the middle of a frame. A sender that reverses bit order, inverts parity, restarts on a late request, or parks the wire high instead of low breaks the expected wire level at once. On the receive side it injects correct and corrupted parity and holds the wire high in listen mode. A listener without the five-period fallback would hang, and one with the wrong sampling point or synchroniser depth would report the wrong byte or report it in the wrong cycle.

// File: rtl/sw_link_pkg.sv
package sw_link_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SYNC_LO,
        TX_SYNC_HI,
        TX_DATA,
        TX_PARITY
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_WAIT_HI,
        RX_BITS,
        RX_TAIL
    } rx_state_t;

    // Bit period in clock cycles from a clock rate in Hz and a period in microseconds.
    function automatic int bit_cycles(input int clk_hz, input int bit_us);
        return ((clk_hz / 1000) * bit_us) / 1000;
    endfunction

endpackage

// File: rtl/sw_link_sync.sv
module sw_link_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES < 2) begin : g_single
            logic r_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= RST_VAL;
                else        r_q <= d;
            end
            assign q = r_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sw_link_tx.sv
module sw_link_tx
    import sw_link_pkg::*;
#(
    parameter int DW      = 8,
    parameter int BIT_CYC = 12,
    parameter int HALF1   = 6,
    parameter int TW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic [DW-1:0] data,
    output logic          busy,
    output logic          line
);

    localparam int            CW     = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [TW-1:0] T_BIT  = TW'(BIT_CYC - 1);
    localparam logic [TW-1:0] T_MARK = TW'(HALF1 - 1);
    localparam logic [CW-1:0] LAST   = CW'(DW - 1);

    tx_state_t     st_q, st_n;
    logic [TW-1:0] tmr_q, tmr_n;
    logic [DW-1:0] sh_q, sh_n;
    logic [CW-1:0] idx_q, idx_n;
    logic          par_q, par_n;
    logic          idle_q, idle_n;
    logic          tmr_done;

    assign tmr_done = (tmr_q == '0);

    // next-state logic
    always_comb begin
        st_n   = st_q;
        tmr_n  = tmr_done ? tmr_q : tmr_q - 1'b1;
        sh_n   = sh_q;
        idx_n  = idx_q;
        par_n  = par_q;
        idle_n = idle_q;
        if (!en) begin
            st_n  = TX_IDLE;
            tmr_n = '0;
        end else begin
            unique case (st_q)
                TX_IDLE: begin
                    if (start) begin
                        st_n  = TX_SYNC_LO;
                        tmr_n = T_BIT;
                        sh_n  = data;
                        par_n = 1'b0;
                    end
                end
                TX_SYNC_LO: begin
                    if (tmr_done) begin
                        st_n  = TX_SYNC_HI;
                        tmr_n = T_MARK;
                    end
                end
                TX_SYNC_HI: begin
                    if (tmr_done) begin
                        st_n  = TX_DATA;
                        tmr_n = T_BIT;
                        idx_n = '0;
                    end
                end
                TX_DATA: begin
                    if (tmr_done) begin
                        par_n = par_q ^ sh_q[DW-1];
                        sh_n  = sh_q << 1;
                        tmr_n = T_BIT;
                        if (idx_q == LAST) st_n = TX_PARITY;
                        else               idx_n = idx_q + 1'b1;
                    end
                end
                TX_PARITY: begin
                    if (tmr_done) begin
                        st_n   = TX_IDLE;
                        idle_n = 1'b0;
                    end
                end
                default: st_n = TX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TX_IDLE;
            tmr_q  <= '0;
            sh_q   <= '0;
            idx_q  <= '0;
            par_q  <= 1'b0;
            idle_q <= 1'b1;
        end else begin
            st_q   <= st_n;
            tmr_q  <= tmr_n;
            sh_q   <= sh_n;
            idx_q  <= idx_n;
            par_q  <= par_n;
            idle_q <= idle_n;
        end
    end

    // outputs
    always_comb begin
        busy = 1'b1;
        line = 1'b0;
        unique case (st_q)
            TX_IDLE:    begin busy = 1'b0; line = idle_q; end
            TX_SYNC_LO: line = 1'b0;
            TX_SYNC_HI: line = 1'b1;
            TX_DATA:    line = sh_q[DW-1];
            TX_PARITY:  line = par_q;
            default:    begin busy = 1'b0; line = 1'b0; end
        endcase
    end

endmodule

// File: rtl/sw_link_rx.sv
module sw_link_rx
    import sw_link_pkg::*;
#(
    parameter int DW       = 8,
    parameter int BIT_CYC  = 12,
    parameter int HALF1    = 6,
    parameter int HALF2    = 6,
    parameter int HUNT_CYC = 60,
    parameter int TW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          line,
    output logic [DW-1:0] data_o,
    output logic          valid_o,
    output logic          perr_o
);

    localparam int            SW      = $clog2(DW + 1);
    localparam logic [TW-1:0] T_BIT   = TW'(BIT_CYC - 1);
    localparam logic [TW-1:0] T_FIRST = TW'(2 * HALF1 - 1);
    localparam logic [TW-1:0] T_TAIL  = TW'(HALF2 - 1);
    localparam logic [TW-1:0] T_HUNT  = TW'(HUNT_CYC - 1);
    localparam logic [SW-1:0] N_DATA  = SW'(DW);

    rx_state_t     st_q, st_n;
    logic [TW-1:0] tmr_q, tmr_n;
    logic [DW-1:0] sh_q, sh_n;
    logic [SW-1:0] ns_q, ns_n;
    logic          bad_q, bad_n;
    logic [DW-1:0] dat_q, dat_n;
    logic          val_q, val_n;
    logic          err_q, err_n;
    logic          tmr_done;

    assign tmr_done = (tmr_q == '0);

    // next-state logic
    always_comb begin
        st_n  = st_q;
        tmr_n = tmr_done ? tmr_q : tmr_q - 1'b1;
        sh_n  = sh_q;
        ns_n  = ns_q;
        bad_n = bad_q;
        dat_n = dat_q;
        val_n = 1'b0;
        err_n = err_q;
        if (!en) begin
            st_n  = RX_HUNT;
            tmr_n = T_HUNT;
        end else begin
            unique case (st_q)
                RX_HUNT: begin
                    if (!line) begin
                        st_n = RX_WAIT_HI;
                    end else if (tmr_done) begin
                        st_n  = RX_BITS;
                        tmr_n = T_FIRST;
                        ns_n  = '0;
                    end
                end
                RX_WAIT_HI: begin
                    if (line) begin
                        st_n  = RX_BITS;
                        tmr_n = T_FIRST;
                        ns_n  = '0;
                    end
                end
                RX_BITS: begin
                    if (tmr_done) begin
                        tmr_n = T_BIT;
                        if (ns_q == N_DATA) begin
                            bad_n = (^sh_q) != line;
                            st_n  = RX_TAIL;
                            tmr_n = T_TAIL;
                        end else begin
                            sh_n = {sh_q[DW-2:0], line};
                            ns_n = ns_q + 1'b1;
                        end
                    end
                end
                RX_TAIL: begin
                    if (tmr_done) begin
                        val_n = 1'b1;
                        dat_n = sh_q;
                        err_n = bad_q;
                        st_n  = RX_HUNT;
                        tmr_n = T_HUNT;
                    end
                end
                default: begin
                    st_n  = RX_HUNT;
                    tmr_n = T_HUNT;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RX_HUNT;
            tmr_q <= T_HUNT;
            sh_q  <= '0;
            ns_q  <= '0;
            bad_q <= 1'b0;
            dat_q <= '0;
            val_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            tmr_q <= tmr_n;
            sh_q  <= sh_n;
            ns_q  <= ns_n;
            bad_q <= bad_n;
            dat_q <= dat_n;
            val_q <= val_n;
            err_q <= err_n;
        end
    end

    // outputs
    always_comb begin
        data_o  = dat_q;
        valid_o = val_q;
        perr_o  = err_q;
    end

endmodule

// File: rtl/sw_byte_link.sv
module sw_byte_link
    import sw_link_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int BIT_US      = 6,
    parameter int HUNT_BITS   = 5,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_mode,
    input  logic          tx_start,
    input  logic [DW-1:0] tx_data,
    output logic          tx_busy,
    output logic          pad_oe,
    output logic          pad_out,
    input  logic          pad_in,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_parity_err
);

    localparam int BIT_CYC  = bit_cycles(CLK_HZ, BIT_US);
    localparam int HALF1    = BIT_CYC / 2;
    localparam int HALF2    = BIT_CYC - HALF1;
    localparam int HUNT_CYC = HUNT_BITS * BIT_CYC;
    localparam int TW       = $clog2(HUNT_CYC + 1);

    logic tx_line;
    logic line_s;

    sw_link_tx #(
        .DW(DW), .BIT_CYC(BIT_CYC), .HALF1(HALF1), .TW(TW)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_mode), .start(tx_start),
        .data(tx_data), .busy(tx_busy), .line(tx_line)
    );

    sw_link_sync #(
        .STAGES(SYNC_STAGES), .RST_VAL(1'b1)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(line_s)
    );

    sw_link_rx #(
        .DW(DW), .BIT_CYC(BIT_CYC), .HALF1(HALF1), .HALF2(HALF2),
        .HUNT_CYC(HUNT_CYC), .TW(TW)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .en(!tx_mode), .line(line_s),
        .data_o(rx_data), .valid_o(rx_valid), .perr_o(rx_parity_err)
    );

    assign pad_oe  = tx_mode;
    assign pad_out = tx_mode & tx_line;

endmodule

// File: rtl/sw_byte_link_chk.sv
module sw_byte_link_chk #(
    parameter int DW      = 8,
    parameter int BIT_CYC = 12,
    parameter int HALF1   = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_mode,
    input logic          tx_start,
    input logic          tx_busy,
    input logic          pad_out,
    input logic [DW-1:0] rx_data,
    input logic          rx_valid,
    input logic          rx_parity_err
);

    localparam int FRAME_CYC = BIT_CYC + HALF1 + (DW + 1) * BIT_CYC;

    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_run <= 0;
        else if (tx_busy) busy_run <= busy_run + 1;
        else              busy_run <= 0;
    end

    assert_start_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode && tx_start && !tx_busy) |=> (tx_busy && !pad_out));

    // R5 too: a restart on a late request would stretch the frame
    assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_busy) && $past(tx_mode)) |-> (busy_run == FRAME_CYC && !pad_out));

    assert_release_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mode |=> !tx_busy);

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_parity_err)));

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_rx_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode && $past(tx_mode)) |-> !rx_valid);

endmodule

bind sw_byte_link sw_byte_link_chk #(
    .DW(DW), .BIT_CYC(BIT_CYC), .HALF1(HALF1)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .tx_start(tx_start),
    .tx_busy(tx_busy), .pad_out(pad_out), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_parity_err(rx_parity_err)
);

// File: tb/sim_sw_byte_link.sv
`timescale 1ns/1ps
module sim_sw_byte_link;

    localparam int CLK_HZ = 1_500_000;
    localparam int BIT_US = 6;
    localparam int B      = 9;
    localparam int H      = B / 2;
    localparam int H2     = B - H;
    localparam int FRAME  = B + H + 9 * B;
    localparam int RXLAT  = 2 + 2 * H + 8 * B + H2;
    localparam int HUNT   = 5 * B;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_mode, tx_start;
    logic [7:0] tx_data;
    logic       tx_busy, pad_oe, pad_out, pad_in;
    logic [7:0] rx_data;
    logic       rx_valid, rx_parity_err;
    logic       remote;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    bit  mon_tx = 0;
    bit  mon_rx = 0;

    always #2.5 clk = ~clk;

    assign pad_in = pad_oe ? pad_out : remote;

    sw_byte_link #(.CLK_HZ(CLK_HZ), .BIT_US(BIT_US)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .tx_start(tx_start),
        .tx_data(tx_data), .tx_busy(tx_busy), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_in(pad_in), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_parity_err(rx_parity_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h, expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural sender model ----------------
    int         cyc = 0;
    bit         started = 0;
    int         s_idx = 0;
    logic [7:0] mdata = 8'h00;

    function automatic bit m_busy();
        int c;
        c = cyc - s_idx;
        return started && c >= 0 && c < FRAME;
    endfunction

    function automatic logic m_line();
        int c;
        int ones;
        if (!started) return 1'b1;
        c = cyc - s_idx;
        if (c < B)         return 1'b0;
        if (c < B + H)     return 1'b1;
        if (c < B + H + 8 * B) return mdata[7 - (c - B - H) / B];
        if (c < FRAME) begin
            ones = 0;
            for (int i = 0; i < 8; i++) ones += mdata[i];
            return (ones % 2) == 1;
        end
        return 1'b0;
    endfunction

    function automatic string m_tag();
        int c;
        if (!started) return "R1";
        c = cyc - s_idx;
        if (c < B)             return "R2";
        if (c < B + H)         return "R10";
        if (c < B + H + 8 * B) return "R2";
        if (c < FRAME)         return "R3";
        return "R4";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else if (tx_mode && tx_start && !m_busy()) begin
            started <= 1'b1;
            s_idx   <= cyc + 1;
            mdata   <= tx_data;
        end
        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n && mon_tx) begin
            if (tx_mode) begin
                chk(pad_oe === 1'b1, "R1", int'(pad_oe), 1);
                chk(pad_out === m_line(), m_tag(), int'(pad_out), int'(m_line()));
                chk(tx_busy === m_busy(), "R4", int'(tx_busy), int'(m_busy()));
            end else begin
                chk(pad_oe === 1'b0 && pad_out === 1'b0, "R6",
                    int'({pad_oe, pad_out}), 0);
                chk(tx_busy === 1'b0, "R5", int'(tx_busy), 0);
            end
        end
    end

    // ---------------- receiver expectation ----------------
    int         rx_due = -1;
    logic [7:0] rx_exp = 8'h00;
    bit         rx_experr = 0;

    always @(negedge clk) begin
        if (rst_n && mon_rx) begin
            if (cyc == rx_due) begin
                chk(rx_valid === 1'b1, "R8", int'(rx_valid), 1);
                chk(rx_data === rx_exp, "R7", int'(rx_data), int'(rx_exp));
                chk(rx_parity_err === rx_experr, "R8", int'(rx_parity_err), int'(rx_experr));
            end else begin
                chk(rx_valid === 1'b0, tx_mode ? "R11" : "R8", int'(rx_valid), 0);
            end
        end
    end

    task automatic send(input logic [7:0] d, input int gap);
        @(negedge clk);
        tx_start = 1'b1;
        tx_data  = d;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit flip);
        @(negedge clk);
        remote = 1'b0;
        repeat (B - 1) @(negedge clk);
        @(negedge clk);
        remote    = 1'b1;
        rx_due    = cyc + 1 + RXLAT;
        rx_exp    = d;
        rx_experr = flip;
        repeat (H) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            remote = d[7 - k];
            repeat (B) @(negedge clk);
        end
        remote = (^d) ^ flip;
        repeat (B) @(negedge clk);
        remote = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        rst_n    = 1'b0;
        tx_mode  = 1'b0;
        tx_start = 1'b0;
        tx_data  = 8'h00;
        remote   = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, released
        chk(tx_busy === 1'b0, "R1", int'(tx_busy), 0);
        chk(rx_valid === 1'b0, "R1", int'(rx_valid), 0);
        chk(pad_oe === 1'b0, "R6", int'(pad_oe), 0);

        // R9: wire held high in listen mode
        begin
            int n;
            n = 1;
            while (rx_valid !== 1'b1 && n < 400) begin
                @(negedge clk);
                n++;
            end
            chk(n >= HUNT && n <= HUNT + RXLAT + 4, "R9", n, HUNT + RXLAT);
            chk(rx_data === 8'hFF, "R9", int'(rx_data), 8'hFF);
            chk(rx_parity_err === 1'b1, "R9", int'(rx_parity_err), 1);
            remote = 1'b0;
        end
        repeat (4) @(negedge clk);

        // sending
        tx_mode = 1'b1;
        mon_tx  = 1'b1;
        mon_rx  = 1'b1;
        repeat (3) @(negedge clk);
        send(8'hA5, FRAME + 3);
        send(8'h80, 30);
        send(8'h11, FRAME);          // R5: arrives mid-frame, ignored
        send(8'h00, FRAME - 1);      // back-to-back next start (R4)
        send(8'hFF, FRAME + 3);
        tx_mode = 1'b0;
        send(8'h3C, 5);              // R5: ignored when released
        @(negedge clk);
        tx_mode = 1'b1;
        repeat (5) @(negedge clk);   // stays parked low
        send(8'h6E, FRAME + 3);

        // receiving
        tx_mode = 1'b0;
        repeat (4) @(negedge clk);
        rx_frame(8'h3C, 1'b0);
        rx_frame(8'h01, 1'b0);
        rx_frame(8'hB7, 1'b1);
        rx_frame(8'h00, 1'b1);
        rx_frame(8'h80, 1'b0);

        mon_tx = 1'b0;
        mon_rx = 1'b0;
        done   = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running, expected finished");
            summary();
            $finish;
        end
    end

endmodule